// File: doc/BRIEF.md
# Dual External Interrupt Request Detector

This block watches two active-low external interrupt pins and turns activity on them into latched request flags for an interrupt controller. Each pin has its own trigger-type bit. With the bit set, the pin raises its request on a falling edge. With the bit clear, the pin raises its request whenever it is held low. Each pin is first passed through a two-flop synchroniser.

A request flag can be cleared in two ways. The interrupt controller can pulse an acknowledge line when it services the request, or software can write the flag through the register port. Software writes can also set a flag, which lets software raise a request on its own. The two type bits and the two flags share one control register, selected by a single address on a simple read/write port. The flags also drive the request outputs directly.

Each input has a small detector state machine with two states. `ST_ARMED` means the last synchronised sample was high. `ST_HELD` means it was low. The transition `ST_ARMED -> ST_HELD` happens on a low sample and is the falling-edge event. The transition `ST_HELD -> ST_ARMED` happens on a high sample and re-arms the detector. In every other case the state is held.

Top module: `xirq_detect`

## Requirements
- R1: After reset both type bits and both request flags are 0, and the control register reads 0x00.
- R2: At address 0x88 the control register reads bit 0 = type bit of input 0, bit 1 = flag of input 0, bit 2 = type bit of input 1, bit 3 = flag of input 1. All higher bits read 0, and any other address reads 0x00.
- R3: A write to any address other than 0x88 changes neither type bit nor either flag.
- R4: A pin level present at a rising clock edge reaches the flag logic through two synchroniser flops. A low level that sets a flag makes the flag read 1 after the third rising edge, counting that edge as the first.
- R5: With the type bit at 1 (edge mode), a flag is set only when a synchronised high sample is followed by a low sample. A pin held low after the flag is cleared does not set the flag again.
- R6: With the type bit at 0 (level mode), the flag is set on every cycle in which the synchronised sample is low. It therefore sets again one cycle after a clear while the pin stays low.
- R7: A 1 on an acknowledge line clears that input's flag on the next edge, unless a hardware set or a register write to that flag happens in the same cycle.
- R8: A write to 0x88 loads both type bits from data bits 0 and 2 and loads both flags from data bits 1 and 3. The write can therefore set flags as well as clear them.
- R9: A hardware set in the same cycle as an acknowledge or a software clear of that flag leaves the flag at 1.
- R10: A software write to a flag in the same cycle as its acknowledge takes the written value.
- R11: Each request output always equals its flag bit as read through the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 2 | Active-low external interrupt pins, asynchronous |
| irq_ack | input | 2 | Service acknowledge, one per input, clears the flag |
| reg_addr | input | 8 | Register port address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| irq_req | output | 2 | Latched request flags |

## Verification
A detector left in the wrong state shows up as a missing or extra request on the first falling edge after it. For example, a detector stuck in `ST_HELD` swallows the next edge, and one stuck in `ST_ARMED` sets the flag again while the pin stays low. Either fault appears on `irq_req` three edges after the pin event. A wrong flag or type bit is visible at once on `reg_rdata` at 0x88. A bad set/clear priority shows on the edge that follows the cycle in which the set and the clear collide. The bench compares every cycle against a cycle-accurate model, so each of these faults is caught within a few cycles of its cause.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    // Detector state: the last synchronised sample seen on the pin
    typedef enum logic {
        ST_ARMED = 1'b0,   // last sample high, a low sample is a falling edge
        ST_HELD  = 1'b1    // last sample low, waiting for release
    } det_state_e;

    // Field positions inside the control register, per input i
    function automatic int type_bit(input int i);
        return 2 * i;
    endfunction

    function automatic int flag_bit(input int i);
        return 2 * i + 1;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic samp,       // synchronised pin level
    input  logic edge_mode,  // 1 = falling edge, 0 = low level
    input  logic ack,
    input  logic sw_wr,
    input  logic sw_val,
    output logic flag
);
    det_state_e state_q, state_d;
    logic       fall_seen;
    logic       hw_set;

    // Next-state logic: the ARMED -> HELD transition is the falling edge
    always_comb begin
        state_d   = state_q;
        fall_seen = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (!samp) begin
                    state_d   = ST_HELD;
                    fall_seen = 1'b1;
                end
            end
            ST_HELD: begin
                if (samp) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    assign hw_set = edge_mode ? fall_seen : !samp;

    // Flag priority: hardware set, then software write, then acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hw_set) begin
            flag <= 1'b1;
        end else if (sw_wr) begin
            flag <= sw_val;
        end else if (ack) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/xirq_regport.sv
module xirq_regport
    import xirq_pkg::*;
#(
    parameter int                 NUM_SRC  = 2,
    parameter int                 ADDR_W   = 8,
    parameter int                 DATA_W   = 8,
    parameter logic [ADDR_W-1:0]  REG_ADDR = 8'h88
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] flags,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_SRC-1:0] type_q,
    output logic [NUM_SRC-1:0] sw_wr,
    output logic [NUM_SRC-1:0] sw_val
);
    logic sel;
    logic wr_hit;

    assign sel    = (addr == REG_ADDR);
    assign wr_hit = wr_en && sel;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                type_q[i] <= 1'b0;
            end else if (wr_hit) begin
                type_q[i] <= wdata[type_bit(i)];
            end
        end
        assign sw_wr[i]  = wr_hit;
        assign sw_val[i] = wdata[flag_bit(i)];
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                rdata[type_bit(i)] = type_q[i];
                rdata[flag_bit(i)] = flags[i];
            end
        end
    end
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect #(
    parameter int                NUM_SRC     = 2,
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h88,
    parameter int                SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_pin_n,
    input  logic [NUM_SRC-1:0] irq_ack,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr_en,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_SRC-1:0] irq_req
);
    logic [NUM_SRC-1:0] pin_sync;
    logic [NUM_SRC-1:0] type_q;
    logic [NUM_SRC-1:0] sw_wr;
    logic [NUM_SRC-1:0] sw_val;
    logic [NUM_SRC-1:0] flag_q;

    xirq_regport #(
        .NUM_SRC  (NUM_SRC),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .REG_ADDR (REG_ADDR)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr_en  (reg_wr_en),
        .wdata  (reg_wdata),
        .flags  (flag_q),
        .rdata  (reg_rdata),
        .type_q (type_q),
        .sw_wr  (sw_wr),
        .sw_val (sw_val)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        xirq_sync #(
            .STAGES    (SYNC_STAGES),
            .RESET_VAL (1'b1)
        ) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (irq_pin_n[i]),
            .q     (pin_sync[i])
        );

        xirq_chan chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .samp      (pin_sync[i]),
            .edge_mode (type_q[i]),
            .ack       (irq_ack[i]),
            .sw_wr     (sw_wr[i]),
            .sw_val    (sw_val[i]),
            .flag      (flag_q[i])
        );
    end

    assign irq_req = flag_q;
endmodule

// File: rtl/xirq_detect_chk.sv
module xirq_detect_chk #(
    parameter int                NUM_SRC  = 2,
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h88
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_ack,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_wr_en,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [NUM_SRC-1:0] samp,
    input logic [NUM_SRC-1:0] type_q
);
    localparam int FIELD_W = 2 * NUM_SRC;

    logic wr_hit;
    assign wr_hit = reg_wr_en && (reg_addr == REG_ADDR);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata >> FIELD_W) == '0);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ch
        // Level mode sets on a low sample, and wins over any clear (R9)
        assert_level_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!type_q[i] && !samp[i]) |=> irq_req[i]);

        assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[i] && !wr_hit && samp[i]) |=> !irq_req[i]);

        assert_sw_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && samp[i]) |=> (irq_req[i] == $past(reg_wdata[2*i+1])));

        assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_req[i]) |-> $past(!samp[i] || (wr_hit && reg_wdata[2*i+1])));

        assert_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_req[i]) |-> $past(irq_ack[i] || wr_hit));

        assert_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == REG_ADDR) |-> (reg_rdata[2*i+1] == irq_req[i]));
    end
endmodule

bind xirq_detect xirq_detect_chk #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_ack   (irq_ack),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_req   (irq_req),
    .samp      (pin_sync),
    .type_q    (type_q)
);

// File: tb/xirq_detect_tb_top.sv
`timescale 1ns/1ps
module xirq_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] pin_n;
    logic [1:0] ack;
    logic [7:0] addr;
    logic       wr_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [1:0] req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    logic [1:0] m_s1, m_s2, m_prev, m_type, m_flag;

    always #5 clk = ~clk;

    xirq_detect dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pin_n (pin_n),
        .irq_ack   (ack),
        .reg_addr  (addr),
        .reg_wr_en (wr_en),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_req   (req)
    );

    function automatic logic [7:0] exp_rdata(input logic [7:0] a);
        if (a != 8'h88) return 8'h00;
        return {4'h0, m_flag[1], m_type[1], m_flag[0], m_type[0]};
    endfunction

    task automatic model_reset();
        m_s1 = 2'b11; m_s2 = 2'b11; m_prev = 2'b11;
        m_type = 2'b00; m_flag = 2'b00;
    endtask

    task automatic model_clock();
        logic [1:0] nf;
        logic       hit;
        hit = wr_en && (addr == 8'h88);
        for (int i = 0; i < 2; i++) begin
            logic fall, hw;
            fall = m_prev[i] && !m_s2[i];
            hw   = m_type[i] ? fall : !m_s2[i];
            if (hw)          nf[i] = 1'b1;
            else if (hit)    nf[i] = wdata[2*i+1];
            else if (ack[i]) nf[i] = 1'b0;
            else             nf[i] = m_flag[i];
        end
        if (hit) m_type = {wdata[2], wdata[0]};
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pin_n;
        m_flag = nf;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        check(tag, {6'b0, req}, {6'b0, m_flag});
        check(tag, rdata, exp_rdata(addr));
    endtask

    task automatic cyc(input string tag, input logic [1:0] p, input logic [1:0] a,
                       input logic w, input logic [7:0] ad, input logic [7:0] d);
        pin_n = p; ack = a; wr_en = w; addr = ad; wdata = d;
        step(tag);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5417));
        pin_n = 2'b11; ack = 2'b00; wr_en = 1'b0; addr = 8'h88; wdata = 8'h00;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        check("R1", {6'b0, req}, 8'h00);
        check("R1", rdata, 8'h00);

        // R8: both inputs to edge mode
        cyc("R8", 2'b11, 2'b00, 1'b1, 8'h88, 8'h05);
        // R4: falling pin 0 shows three edges later
        cyc("R4", 2'b10, 2'b00, 1'b0, 8'h88, 8'h00);
        cyc("R4", 2'b10, 2'b00, 1'b0, 8'h88, 8'h00);
        check("R4", {7'b0, req[0]}, 8'h00);
        cyc("R4", 2'b10, 2'b00, 1'b0, 8'h88, 8'h00);
        check("R4", {7'b0, req[0]}, 8'h01);
        // R5: acknowledge while held low, no re-trigger
        cyc("R7", 2'b10, 2'b01, 1'b0, 8'h88, 8'h00);
        repeat (3) cyc("R5", 2'b10, 2'b00, 1'b0, 8'h88, 8'h00);
        check("R5", {7'b0, req[0]}, 8'h00);
        repeat (3) cyc("R5", 2'b11, 2'b00, 1'b0, 8'h88, 8'h00);

        // R6: input 1 in level mode, re-sets after acknowledge
        cyc("R8", 2'b11, 2'b00, 1'b1, 8'h88, 8'h01);
        repeat (3) cyc("R6", 2'b01, 2'b00, 1'b0, 8'h88, 8'h00);
        check("R6", {7'b0, req[1]}, 8'h01);
        // R9: hardware set beats acknowledge and software clear
        cyc("R9", 2'b01, 2'b10, 1'b0, 8'h88, 8'h00);
        check("R9", {7'b0, req[1]}, 8'h01);
        cyc("R9", 2'b01, 2'b00, 1'b1, 8'h88, 8'h01);
        check("R9", {7'b0, req[1]}, 8'h01);
        repeat (3) cyc("R6", 2'b11, 2'b00, 1'b0, 8'h88, 8'h00);
        cyc("R8", 2'b11, 2'b00, 1'b1, 8'h88, 8'h01);
        check("R8", rdata, 8'h01);

        // R3: write elsewhere has no effect, R2: other address reads zero
        cyc("R3", 2'b11, 2'b00, 1'b1, 8'h89, 8'hFF);
        check("R2", rdata, 8'h00);
        cyc("R3", 2'b11, 2'b00, 1'b0, 8'h88, 8'h00);
        check("R3", rdata, 8'h01);

        // R8: software sets both flags
        cyc("R8", 2'b11, 2'b00, 1'b1, 8'h88, 8'h0B);
        check("R8", rdata, 8'h0B);
        // R10: software write beats acknowledge
        cyc("R10", 2'b11, 2'b11, 1'b1, 8'h88, 8'h0B);
        check("R10", {6'b0, req}, 8'h03);
        cyc("R10", 2'b11, 2'b11, 1'b1, 8'h88, 8'h00);
        check("R10", {6'b0, req}, 8'h00);

        // R11: constrained random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] p;
            logic [1:0] a;
            logic       w;
            logic [7:0] ad;
            logic [7:0] d;
            p = pin_n;
            for (int i = 0; i < 2; i++)
                if ($urandom_range(7) == 0) p[i] = ~p[i];
            a  = ($urandom_range(5) == 0) ? 2'($urandom) : 2'b00;
            w  = ($urandom_range(9) == 0);
            ad = ($urandom_range(7) == 0) ? 8'($urandom) : 8'h88;
            d  = 8'($urandom);
            cyc("R11", p, a, w, ad, d);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule